// File: doc/BRIEF.md
# Four-Way Vector Interleave Unit

This block rearranges four source vectors of VL bits into four destination vectors by a four-way element interleave. Each destination takes one contiguous quarter of every source: destination r reads the quarter that starts at element r x quads, where quads = VL / (4 x element width). Within that destination, the elements of the four sources alternate, source 0 first.

The element width is chosen per operation. A two-bit size code selects 8, 16, 32 or 64 bits, and a separate wide flag forces 128 bits. The vector length and the largest vector length the surrounding machine supports are elaboration parameters. Combinations the configuration cannot support are reported, not executed.

A request is one cycle with `start_i` high. The result is registered, so `done_o` pulses in the following cycle and the destinations and the illegal flag are valid from then on. No element is masked: every element of all four destinations is written on a legal request. A new request may be issued in every cycle.

Top module: `zip4_interleave`

## Requirements
- R1: With `wide_i` low, `size_i` sets the element width to 8 << `size_i` bits: code 0 is 8, 1 is 16, 2 is 32 and 3 is 64.
- R2: With `wide_i` high, the element width is 128 bits whatever `size_i` holds.
- R3: After a legal request, for r and k in 0..3 and q in 0..quads-1, element 4q+k of destination r equals element r x quads + q of source k. Element i of a vector occupies bits [i x width + width - 1 : i x width], and every element of every destination is written.
- R4: `done_o` is high in exactly those cycles that follow a cycle with `start_i` high, including back-to-back requests.
- R5: A request is illegal when VL is below four times the element width, when the width is 64 and the maximum supported length is below 256 bits, or when the width is 128 and the maximum supported length is below 512 bits. With the default parameters (VL = 256, maximum 256), 128-bit requests are illegal and all other widths are legal.
- R6: On an illegal request all four destinations keep their previous values, and `illegal_o` is high from the cycle that `done_o` pulses.
- R7: A legal request clears `illegal_o` in the cycle that `done_o` pulses. `illegal_o` does not change between requests.
- R8: While `start_i` is low, the destinations hold their values whatever the sources, size and wide inputs do.
- R9: After reset, all destinations are zero, and `done_o` and `illegal_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe, one per cycle |
| size_i | input | 2 | Element width code, 8 << code bits |
| wide_i | input | 1 | Forces a 128-bit element width |
| src0_i | input | VL_BITS | Source vector 0 |
| src1_i | input | VL_BITS | Source vector 1 |
| src2_i | input | VL_BITS | Source vector 2 |
| src3_i | input | VL_BITS | Source vector 3 |
| dst0_o | output | VL_BITS | Destination vector 0 |
| dst1_o | output | VL_BITS | Destination vector 1 |
| dst2_o | output | VL_BITS | Destination vector 2 |
| dst3_o | output | VL_BITS | Destination vector 3 |
| done_o | output | 1 | Pulses one cycle after each request |
| illegal_o | output | 1 | Last request had an unsupported configuration |

## Verification
Every legal width code is run with several sets of random sources, each compared with a nested-loop model. Fully random data shows whether a width was decoded to the wrong element boundary, and it exposes a wrong quarter base or a wrong source order. Requests with the wide flag set, at several size codes, separate a correct override and legality rejection from any execution at 128 bits. The bench also checks that a later legal request clears the flag, and that outputs hold when sources change without a request. Back-to-back requests show whether `done_o` and the captured result move together on every cycle.

// File: rtl/zip4_pkg.sv
package zip4_pkg;

   // Element width choices; the numeric value is log2(width / 8).
   typedef enum logic [2:0] {
      EW_8   = 3'd0,
      EW_16  = 3'd1,
      EW_32  = 3'd2,
      EW_64  = 3'd3,
      EW_128 = 3'd4
   } ew_e;

   localparam int unsigned EW_COUNT = 5;
   localparam int unsigned LANES    = 4;

   function automatic int unsigned ew_bits(input int unsigned idx);
      return 8 << idx;
   endfunction

   // Legality of one width for a given vector length and machine maximum.
   function automatic bit ew_legal(input int unsigned idx,
                                   input int unsigned vl,
                                   input int unsigned max_vl);
      bit ok;
      ok = (vl >= LANES * ew_bits(idx));
      if (idx == 3 && max_vl < 256) ok = 1'b0;
      if (idx == 4 && max_vl < 512) ok = 1'b0;
      return ok;
   endfunction

endpackage

// File: rtl/zip4_cfg_decode.sv
module zip4_cfg_decode
   import zip4_pkg::*;
#(
   parameter int unsigned VL_BITS     = 256,
   parameter int unsigned MAX_VL_BITS = 256
) (
   input  logic [1:0] size_i,
   input  logic       wide_i,
   output ew_e        ew_o,
   output logic       bad_o
);

   function automatic logic [EW_COUNT-1:0] build_legal();
      logic [EW_COUNT-1:0] v;
      for (int unsigned i = 0; i < EW_COUNT; i++) v[i] = ew_legal(i, VL_BITS, MAX_VL_BITS);
      return v;
   endfunction

   localparam logic [EW_COUNT-1:0] LEGAL_MAP = build_legal();

   always_comb begin
      if (wide_i) ew_o = EW_128;
      else        ew_o = ew_e'({1'b0, size_i});
   end

   assign bad_o = ~LEGAL_MAP[ew_o];

   // R2: the wide flag always wins over the size code
   always_comb begin
      if (wide_i) p_wide_override_r2: assert (ew_o == EW_128);
   end

endmodule

// File: rtl/zip4_lane_shuffle.sv
module zip4_lane_shuffle
   import zip4_pkg::*;
#(
   parameter int unsigned VL_BITS = 256,
   parameter int unsigned ELEM_W  = 8
) (
   input  logic [LANES-1:0][VL_BITS-1:0] src_i,
   output logic [LANES-1:0][VL_BITS-1:0] dst_o
);

   localparam int unsigned QUADS = VL_BITS / (LANES * ELEM_W);

   if (QUADS < 1) begin : g_bad_width
      $error("zip4_lane_shuffle: ELEM_W too wide for VL_BITS");
   end

   // Destination r, group q, lane k  <=  source k, element r*QUADS+q
   for (genvar r = 0; r < LANES; r++) begin : g_dst
      for (genvar q = 0; q < QUADS; q++) begin : g_grp
         for (genvar k = 0; k < LANES; k++) begin : g_lane
            assign dst_o[r][(LANES*q+k)*ELEM_W +: ELEM_W] =
                   src_i[k][(r*QUADS+q)*ELEM_W +: ELEM_W];
         end
      end
   end

endmodule

// File: rtl/zip4_interleave.sv
module zip4_interleave
   import zip4_pkg::*;
#(
   parameter int unsigned VL_BITS     = 256,
   parameter int unsigned MAX_VL_BITS = 256
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [1:0]         size_i,
   input  logic               wide_i,
   input  logic [VL_BITS-1:0] src0_i,
   input  logic [VL_BITS-1:0] src1_i,
   input  logic [VL_BITS-1:0] src2_i,
   input  logic [VL_BITS-1:0] src3_i,
   output logic [VL_BITS-1:0] dst0_o,
   output logic [VL_BITS-1:0] dst1_o,
   output logic [VL_BITS-1:0] dst2_o,
   output logic [VL_BITS-1:0] dst3_o,
   output logic               done_o,
   output logic               illegal_o
);

   // Elaboration-time parameter checks
   if (VL_BITS < 128 || VL_BITS > 2048 || (VL_BITS & (VL_BITS - 1)) != 0) begin : g_chk_vl
      $error("zip4_interleave: VL_BITS must be a power of two in 128..2048");
   end
   if (MAX_VL_BITS < VL_BITS) begin : g_chk_max
      $error("zip4_interleave: MAX_VL_BITS must not be below VL_BITS");
   end

   ew_e                                    ew;
   logic                                   cfg_bad;
   logic [LANES-1:0][VL_BITS-1:0]          src_vec;
   logic [EW_COUNT-1:0][LANES-1:0][VL_BITS-1:0] net_res;
   logic [LANES-1:0][VL_BITS-1:0]          dst_q;

   assign src_vec = {src3_i, src2_i, src1_i, src0_i};

   zip4_cfg_decode #(
      .VL_BITS     (VL_BITS),
      .MAX_VL_BITS (MAX_VL_BITS)
   ) cfg_i (
      .size_i (size_i),
      .wide_i (wide_i),
      .ew_o   (ew),
      .bad_o  (cfg_bad)
   );

   // One shuffle network per element width that fits the vector length
   for (genvar w = 0; w < EW_COUNT; w++) begin : g_width
      if (VL_BITS >= LANES * (8 << w)) begin : g_fit
         zip4_lane_shuffle #(
            .VL_BITS (VL_BITS),
            .ELEM_W  (8 << w)
         ) shuf_i (
            .src_i (src_vec),
            .dst_o (net_res[w])
         );
      end else begin : g_nofit
         assign net_res[w] = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dst_q     <= '0;
         done_o    <= 1'b0;
         illegal_o <= 1'b0;
      end else begin
         done_o <= start_i;
         if (start_i) begin
            illegal_o <= cfg_bad;
            if (!cfg_bad) dst_q <= net_res[ew];
         end
      end
   end

   assign dst0_o = dst_q[0];
   assign dst1_o = dst_q[1];
   assign dst2_o = dst_q[2];
   assign dst3_o = dst_q[3];

   // R4: done follows every request by one cycle
   p_done_after_start_r4: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> done_o);
   p_no_spurious_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> !done_o);

   // R6: illegal request leaves destinations untouched and raises the flag
   p_hold_on_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && cfg_bad) |=> ($stable(dst0_o) && $stable(dst1_o) &&
                                $stable(dst2_o) && $stable(dst3_o) && illegal_o));

   // R7: legal request clears the flag; flag steady between requests
   p_legal_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (start_i && !cfg_bad) |=> !illegal_o);

   // R8: no request, no change
   p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !start_i |=> ($stable(dst0_o) && $stable(dst1_o) && $stable(dst2_o) &&
                    $stable(dst3_o) && $stable(illegal_o)));

endmodule

// File: tb/zip4_interleave_tb_top.sv
module zip4_interleave_tb_top;

   localparam int unsigned VL   = 256;
   localparam int unsigned MAXV = 256;

   typedef struct packed {
      logic [3:0][VL-1:0] d;
      logic               ill;
   } exp_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [1:0]    size_i = 2'd0;
   logic          wide_i = 1'b0;
   logic [VL-1:0] src0_i = '0, src1_i = '0, src2_i = '0, src3_i = '0;
   logic [VL-1:0] dst0_o, dst1_o, dst2_o, dst3_o;
   logic          done_o, illegal_o;

   int unsigned n_checks = 0;
   int unsigned n_fails  = 0;
   bit          finished = 1'b0;

   exp_t               sb_q[$];
   logic [3:0][VL-1:0] mdl_d = '0;
   logic               mdl_ill = 1'b0;

   always #4 clk = ~clk; // 125 MHz

   zip4_interleave #(.VL_BITS(VL), .MAX_VL_BITS(MAXV)) dut_i (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .size_i(size_i), .wide_i(wide_i),
      .src0_i(src0_i), .src1_i(src1_i), .src2_i(src2_i), .src3_i(src3_i),
      .dst0_o(dst0_o), .dst1_o(dst1_o), .dst2_o(dst2_o), .dst3_o(dst3_o),
      .done_o(done_o), .illegal_o(illegal_o));

   function automatic logic [VL-1:0] rand_vec();
      logic [VL-1:0] v;
      for (int i = 0; i < VL / 32; i++) v[i*32 +: 32] = $urandom;
      return v;
   endfunction

   task automatic check(input string req, input logic [VL-1:0] act, input logic [VL-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // Driver: applies one request and pushes the model's result
   task automatic issue(input logic [1:0] sz, input logic wd);
      logic [3:0][VL-1:0] s;
      int unsigned w, quads;
      bit ok;
      exp_t e;
      for (int k = 0; k < 4; k++) s[k] = rand_vec();
      src0_i = s[0]; src1_i = s[1]; src2_i = s[2]; src3_i = s[3];
      size_i = sz; wide_i = wd; start_i = 1'b1;
      w  = wd ? 128 : (8 << sz);                  // R1, R2
      ok = (VL >= 4 * w);                         // R5
      if (w == 64  && MAXV < 256) ok = 0;
      if (w == 128 && MAXV < 512) ok = 0;
      if (ok) begin
         quads = VL / (4 * w);
         for (int r = 0; r < 4; r++)
            for (int q = 0; q < int'(quads); q++)
               for (int k = 0; k < 4; k++)
                  for (int b = 0; b < int'(w); b++)
                     mdl_d[r][(4*q+k)*w + b] = s[k][(r*quads+q)*w + b]; // R3
         mdl_ill = 1'b0;                          // R7
      end else begin
         mdl_ill = 1'b1;                          // R6
      end
      e.d = mdl_d; e.ill = mdl_ill;
      sb_q.push_back(e);
      @(negedge clk);
   endtask

   // Monitor: pops one expected item per done pulse
   always @(negedge clk) begin
      if (rst_n && done_o) begin
         exp_t e;
         if (sb_q.size() == 0) begin
            n_checks++; n_fails++;
            $display("FAIL R4: actual done=1 expected done=0 (no request pending)");
         end else begin
            e = sb_q.pop_front();
            check("R3 dst0", dst0_o, e.d[0]);
            check("R3 dst1", dst1_o, e.d[1]);
            check("R3 dst2", dst2_o, e.d[2]);
            check("R3 dst3", dst3_o, e.d[3]);
            check("R6/R7 illegal", {{(VL-1){1'b0}}, illegal_o}, {{(VL-1){1'b0}}, e.ill});
         end
      end
   end

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 dst0", dst0_o, '0);
      check("R9 dst1", dst1_o, '0);
      check("R9 dst2", dst2_o, '0);
      check("R9 dst3", dst3_o, '0);
      check("R9 flags", {{(VL-2){1'b0}}, done_o, illegal_o}, '0);
      rst_n = 1'b1;
      @(negedge clk);

      // R1/R3: every size code, several random operand sets
      for (int sz = 0; sz < 4; sz++)
         for (int n = 0; n < 3; n++) begin
            issue(2'(sz), 1'b0);
            start_i = 1'b0;
            @(negedge clk);
         end

      // R2/R5/R6: wide flag at several size codes is illegal here
      for (int sz = 0; sz < 4; sz += 3) begin
         issue(2'(sz), 1'b1);
         start_i = 1'b0;
         @(negedge clk);
      end

      // R7: legal request clears the flag
      issue(2'd2, 1'b0);
      start_i = 1'b0;
      @(negedge clk);

      // R4: back-to-back requests, mixed widths and an illegal one between
      issue(2'd0, 1'b0);
      issue(2'd3, 1'b0);
      issue(2'd1, 1'b1);
      issue(2'd1, 1'b0);
      start_i = 1'b0;
      @(negedge clk);
      @(negedge clk);

      // R8: inputs change with no request; outputs and flag hold
      for (int n = 0; n < 4; n++) begin
         src0_i = rand_vec(); src1_i = rand_vec(); src2_i = rand_vec(); src3_i = rand_vec();
         size_i = 2'(n); wide_i = n[0];
         @(negedge clk);
         check("R8 dst0", dst0_o, mdl_d[0]);
         check("R8 dst3", dst3_o, mdl_d[3]);
         check("R4 done idle", {{(VL-1){1'b0}}, done_o}, '0);
      end

      n_checks++;
      if (sb_q.size() != 0) begin
         n_fails++;
         $display("FAIL R4: actual %0d pending results expected 0", sb_q.size());
      end
      finish_run();
   end

endmodule